// File: doc/BRIEF.md
# Serial Key Programming Entry with Multiplexed Address Port

This block decides when a small controller leaves normal operation and enters a state where its 1024-byte program store can be written or read back from the pins. Every decision is taken on the raw oscillator clock. The reset pin is sampled on every rising edge. Holding it high long enough counts as a full reset. After the pin next goes low, the same pin carries a serial unlock key, least significant bit first. Only an exact key match enables programming.

Once programming is enabled, one 8-bit port supplies the 10-bit memory address in two halves. A select pin says which half is on the port. Each half is kept in its own register, so the address is complete after both halves have been given once. A verify/program pin sets the direction of the 8-bit data port. In verify the port drives the memory word at the current address. In program the port is an input, and a falling edge on the verify/program pin issues a single-cycle write into memory.

Top module: `pgm_entry_mux`

## Requirements
- R1: `RST_CYC` (24) consecutive high samples of `rst_pin` form a full reset. A full reset clears `prog_mode`, sets `mem_addr` to 0 and holds `mem_we` low. A high run of 23 samples or fewer is not a full reset.
- R2: After a full reset, the first low sample of `rst_pin` is a start marker. The `KEY_W` (10) samples after it are compared, least significant bit first, with `KEY` (default 10'h16B). `prog_mode` reads 1 right after the edge that samples the last matching bit.
- R3: A sample that differs from the expected key bit sends the comparison back to key bit 0. That sample is discarded. A partial key never sets `prog_mode`.
- R4: `prog_mode` stays set until the next full reset. High pulses shorter than `RST_CYC` samples leave it set.
- R5: In programming mode, with `sel_hi` = 0 at an edge, `addr_port` is stored into `mem_addr[7:0]` and `mem_addr[9:8]` is kept.
- R6: In programming mode, with `sel_hi` = 1 at an edge, `addr_port[1:0]` is stored into `mem_addr[9:8]`. `addr_port[7:2]` is ignored and `mem_addr[7:0]` is kept.
- R7: In programming mode, while `vfy_pin` = 1, `data_oe` = 1 and `data_o` follows `mem_rdata` in the same cycle. While `vfy_pin` = 0, `data_oe` = 0.
- R8: In programming mode, `vfy_pin` sampled 1 at one edge and 0 at the next edge makes `mem_we` high for exactly the cycle after that second edge. `mem_wdata` equals `data_i` as sampled at that second edge.
- R9: When an address half is stored at the same edge that starts a write strobe, `mem_addr` already shows the new half during the strobe cycle.
- R10: Outside programming mode, `mem_addr` does not change, `data_oe` = 0 and `mem_we` = 0, whatever `sel_hi`, `addr_port`, `vfy_pin` and `data_i` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw oscillator clock |
| rst_pin | input | 1 | Reset pin; also carries the serial key |
| sel_hi | input | 1 | 0: `addr_port` holds the low address byte; 1: it holds the high byte |
| vfy_pin | input | 1 | 1: verify (read back); 0: program |
| addr_port | input | 8 | Multiplexed address byte |
| data_i | input | 8 | Data port input value |
| data_o | output | 8 | Data port output value |
| data_oe | output | 1 | Data port output enable |
| mem_addr | output | 10 | Assembled memory address |
| mem_rdata | input | 8 | Memory read data |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Single-cycle memory write strobe |
| prog_mode | output | 1 | Programming state active |

## Verification
Two events can share one clock edge: storing an address half, and detecting the falling edge of the verify/program pin that starts a write. The bench provokes this by driving a new low address byte in the same cycle that it drops `vfy_pin` and presents write data. During the strobe cycle it then expects `mem_addr` to already contain the new byte. A separate table of sequential address-port vectors checks how the two halves build up when they are not aligned with a write.

// File: rtl/pgm_entry_mux.sv
module pgm_entry_mux #(
  parameter int          KEY_W   = 10,
  parameter logic [KEY_W-1:0] KEY = 10'h16B,
  parameter int          RST_CYC = 24,
  parameter int          ADDR_W  = 10,
  parameter int          DW      = 8
) (
  input  logic              clk,
  input  logic              rst_pin,
  input  logic              sel_hi,
  input  logic              vfy_pin,
  input  logic [DW-1:0]     addr_port,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o,
  output logic              data_oe,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic              prog_mode
);
  localparam int HI_W = ADDR_W - DW;
  localparam int CW   = $clog2(RST_CYC);
  localparam int IW   = $clog2(KEY_W);

  logic [CW-1:0]   hcnt;
  logic [IW-1:0]   idx;
  logic            armed, live, vfy_d;
  logic [DW-1:0]   lo_q;
  logic [HI_W-1:0] hi_q;
  logic            full_rst;

  assign full_rst = rst_pin && (hcnt == CW'(RST_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_pin)                         hcnt <= '0;
    else if (hcnt != CW'(RST_CYC - 1))    hcnt <= hcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (full_rst) begin
      prog_mode <= 1'b0;
      armed     <= 1'b1;
      live      <= 1'b0;
      idx       <= '0;
    end else begin
      if (armed && !rst_pin) begin
        armed <= 1'b0;
        live  <= 1'b1;
      end
      if (live) begin
        if (rst_pin == KEY[idx]) begin
          if (idx == IW'(KEY_W - 1)) begin
            prog_mode <= 1'b1;
            live      <= 1'b0;
            idx       <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end else begin
          idx <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (full_rst) begin
      lo_q      <= '0;
      hi_q      <= '0;
      vfy_d     <= 1'b1;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      vfy_d  <= vfy_pin;
      mem_we <= prog_mode && vfy_d && !vfy_pin;
      if (prog_mode && vfy_d && !vfy_pin) mem_wdata <= data_i;
      if (prog_mode && !sel_hi) lo_q <= addr_port;
      if (prog_mode &&  sel_hi) hi_q <= addr_port[HI_W-1:0];
    end
  end

  assign mem_addr = {hi_q, lo_q};
  assign data_oe  = prog_mode && vfy_pin;
  assign data_o   = mem_rdata;
endmodule

// File: rtl/pgm_entry_chk.sv
module pgm_entry_chk #(
  parameter int KEY_W = 10,
  parameter logic [KEY_W-1:0] KEY = 10'h16B,
  parameter int RST_CYC = 24,
  parameter int ADDR_W = 10,
  parameter int CW = 5
) (
  input logic              clk,
  input logic              rst_pin,
  input logic              vfy_pin,
  input logic              prog_mode,
  input logic              data_oe,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CW-1:0]     hcnt
);
  logic up_q = 1'b0;
  always_ff @(posedge clk)
    if (rst_pin && hcnt == CW'(RST_CYC - 1)) up_q <= 1'b1;

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!up_q)
    mem_we |=> !mem_we);

  // R8
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!up_q)
    mem_we |-> (!$past(vfy_pin) && $past(vfy_pin, 2)));

  // R4
  exit_by_reset_chk: assert property (@(posedge clk) disable iff (!up_q)
    $fell(prog_mode) |-> $past(rst_pin));

  // R2
  entry_last_bit_chk: assert property (@(posedge clk) disable iff (!up_q)
    $rose(prog_mode) |-> ($past(rst_pin) == KEY[KEY_W-1]));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!up_q)
    !prog_mode |-> (!data_oe && !mem_we));

  // R10
  idle_addr_chk: assert property (@(posedge clk) disable iff (!up_q)
    (!prog_mode && !rst_pin) |=> $stable(mem_addr));
endmodule

bind pgm_entry_mux pgm_entry_chk #(
  .KEY_W(KEY_W), .KEY(KEY), .RST_CYC(RST_CYC), .ADDR_W(ADDR_W), .CW(CW)
) u_chk (
  .clk(clk), .rst_pin(rst_pin), .vfy_pin(vfy_pin), .prog_mode(prog_mode),
  .data_oe(data_oe), .mem_we(mem_we), .mem_addr(mem_addr), .hcnt(hcnt)
);

// File: tb/sim_pgm_entry_mux.sv
module sim_pgm_entry_mux;
  localparam int PERIOD = 10;
  localparam logic [9:0] KEY = 10'h16B;

  logic clk = 1'b0;
  logic rst_pin = 1'b0, sel_hi = 1'b0, vfy_pin = 1'b1;
  logic [7:0] addr_port = '0, data_i = '0, mem_rdata = '0;
  logic [7:0] data_o, mem_wdata;
  logic       data_oe, mem_we, prog_mode;
  logic [9:0] mem_addr;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  pgm_entry_mux u0 (
    .clk(clk), .rst_pin(rst_pin), .sel_hi(sel_hi), .vfy_pin(vfy_pin),
    .addr_port(addr_port), .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .prog_mode(prog_mode)
  );

  // {sel_hi, addr_port, expected mem_addr}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 8'h3C, 10'h03C},
    {1'b1, 8'hFE, 10'h23C},
    {1'b0, 8'h81, 10'h281},
    {1'b1, 8'h01, 10'h181},
    {1'b1, 8'h07, 10'h381},
    {1'b0, 8'h00, 10'h300}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic send_key();
    for (int i = 0; i < 10; i++) begin rst_pin = KEY[i]; step(); end
    rst_pin = 1'b0;
  endtask

  task automatic full_reset(int n);
    rst_pin = 1'b1;
    repeat (n) step();
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    full_reset(24);
    check("R1 prog cleared", prog_mode, 0);
    check("R1 addr cleared", mem_addr, 0);
    check("R1 we low", mem_we, 0);
    rst_pin = 1'b0; step();               // start marker

    // R10: stimulus while not yet unlocked
    sel_hi = 0; addr_port = 8'h55; vfy_pin = 1; step();
    sel_hi = 1; addr_port = 8'h03; step();
    check("R10 addr unchanged", mem_addr, 0);
    check("R10 oe low", data_oe, 0);
    vfy_pin = 0; data_i = 8'hAA; step();
    check("R10 no strobe", mem_we, 0);
    vfy_pin = 1; step();

    // R3: partial key with a wrong bit
    rst_pin = KEY[0]; step(); rst_pin = KEY[1]; step(); rst_pin = KEY[2]; step();
    rst_pin = ~KEY[3]; step();
    for (int i = 0; i < 9; i++) begin rst_pin = KEY[i]; step(); end
    check("R3 not entered before last bit", prog_mode, 0);
    rst_pin = KEY[9]; step(); rst_pin = 0;
    check("R2 entered on full key", prog_mode, 1);

    // R5 R6 vector table
    vfy_pin = 1;
    foreach (VEC[k]) begin
      sel_hi = VEC[k][18]; addr_port = VEC[k][17:10]; step();
      check("R5/R6 address assembly", mem_addr, VEC[k][9:0]);
    end

    // R7
    mem_rdata = 8'hC3; #1;
    check("R7 oe in verify", data_oe, 1);
    check("R7 data follows memory", data_o, 8'hC3);
    mem_rdata = 8'h19; #1;
    check("R7 data follows change", data_o, 8'h19);

    // R8 write strobe
    sel_hi = 1; addr_port = 8'h01; step();  // addr 0x100
    vfy_pin = 0; data_i = 8'h5A; step();
    check("R8 strobe high", mem_we, 1);
    check("R8 write data", mem_wdata, 8'h5A);
    check("R7 oe low in program", data_oe, 0);
    data_i = 8'h00; step();
    check("R8 strobe one cycle", mem_we, 0);
    check("R8 data held", mem_wdata, 8'h5A);

    // R9 same-edge address update and strobe
    vfy_pin = 1; step();
    sel_hi = 0; addr_port = 8'h44; vfy_pin = 0; data_i = 8'h9E; step();
    check("R9 strobe", mem_we, 1);
    check("R9 new address in strobe cycle", mem_addr, 10'h144);
    check("R9 data", mem_wdata, 8'h9E);
    vfy_pin = 1; step();

    // R4 / R1: 23 highs do not exit, 24 do
    full_reset(23); rst_pin = 0; step();
    check("R4 short pulse keeps mode", prog_mode, 1);
    full_reset(24);
    check("R1 full reset exits", prog_mode, 0);
    check("R1 addr cleared again", mem_addr, 0);
    rst_pin = 0; step();
    send_key();
    check("R2 re-entry after reset", prog_mode, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule